// File: doc/BRIEF.md
# Packed Lane Shifter with Saturation and Rounding

This block shifts a 32-bit operand that is treated as packed lanes. It has three lane modes: four unsigned bytes, two signed halfwords, or a single signed word. A left shift checks each lane for bits lost past its top (for bytes) or its sign (for signed lanes). Signed lanes can clamp to their limits. A right shift is logical on bytes and arithmetic on signed lanes, and signed lanes can round half-up using the last bit shifted out.

Each accepted operation gives a registered result one cycle later. Any lane overflow sets a sticky bit in an 8-bit status field. That bit stays set until a synchronous clear input is asserted. The block sits in an execution pipeline, and the surrounding logic drives one operation per valid strobe.

Top module: `lane_shift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_data`, `res_valid` and `status_flags` become zero.
- R2: `res_valid` equals `op_valid` of the previous cycle. The result of an operation accepted at an edge appears on `res_data` right after that edge.
- R3: Byte mode (`op_mode` = 2'b00), left (`op_dir` = 0), shift n = `op_amount[2:0]`. Each lane gives the low 8 bits of its shifted value and is never saturated. A lane overflows when any of its bits 7 down to 8−n is 1.
- R4: Byte mode, right (`op_dir` = 1). Each unsigned 8-bit lane is shifted right by `op_amount[2:0]`, and zeros enter at the top.
- R5: Halfword mode (`op_mode` = 2'b01), left, shift n = `op_amount[3:0]`. A lane overflows when any of its bits 14 down to 15−n differs from bit 15. With `op_satrnd` = 1, an overflowing lane becomes 0x7FFF if its bit 15 was 0, and 0x8000 if it was 1. With `op_satrnd` = 0, the lane keeps the low 16 bits of the shifted value.
- R6: Halfword mode, right. Each lane is shifted arithmetically by n = `op_amount[3:0]`. With `op_satrnd` = 1 and n ≠ 0, bit n−1 of the original lane is added to the shifted lane.
- R7: Word mode (`op_mode` = 2'b10 or 2'b11), left, shift n = `op_amount[4:0]`. The word overflows when any of bits 30 down to 31−n differs from bit 31. On overflow the result is always 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one, whatever `op_satrnd` is.
- R8: Word mode, right. The shift is arithmetic, and for n ≠ 0 it always adds bit n−1 of the original operand, whatever `op_satrnd` is.
- R9: A shift amount of zero in the selected mode returns the operand unchanged and reports no overflow.
- R10: `status_flags[6]` is set after an accepted operation in which any lane overflowed. It stays set until `flag_clear` is high at an edge. A new overflow in that same cycle leaves it set. The other seven bits are always 0.
- R11: When `op_valid` is low, `res_data` holds its value and `status_flags[6]` cannot become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_data | input | 32 | Packed operand |
| op_amount | input | 5 | Shift amount; the low 3/4/5 bits are used in byte/halfword/word mode |
| op_dir | input | 1 | 0 shifts left, 1 shifts right |
| op_mode | input | 2 | 00 bytes, 01 halfwords, 1x word |
| op_satrnd | input | 1 | Saturate on a left shift / round on a right shift, for halfwords |
| flag_clear | input | 1 | Synchronous clear of the sticky status |
| res_data | output | 32 | Registered result |
| res_valid | output | 1 | Result strobe |
| status_flags | output | 8 | Sticky status field; bit 6 is overflow |

## Verification
The bench builds the block with its default parameters: a 32-bit operand, an 8-bit status field and overflow at index 6. With these values the 5-bit amount reaches every word shift from 0 to 31, including shifts where only the sign survives. The halfword amount reaches 15, where a single stray bit trips overflow. Directed cases cover boundary patterns such as 0x4000 and 0xC000 shifted by one, and clamping in both directions. A long run of random operations with periodic clears is then compared every clock against an integer reference model.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned FLAGS_W = 8;
    localparam int unsigned OVF_BIT = 6;

    typedef enum logic [1:0] {
        LM_BYTE  = 2'b00,
        LM_HALF  = 2'b01,
        LM_WORD  = 2'b10,
        LM_WORD2 = 2'b11
    } lane_mode_e;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              ovf;
    } shift_out_t;

    // Largest positive / most negative value of a W-bit signed lane
    function automatic logic [WORD_W-1:0] sat_limit(input int unsigned w, input logic neg);
        logic [WORD_W-1:0] v;
        v = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            if (i < int'(w) - 1) v[i] = ~neg;
            else if (i == int'(w) - 1) v[i] = neg;
        end
        return v;
    endfunction

endpackage

// File: rtl/ls_byte_lane.sv
module ls_byte_lane #(
    parameter int W  = 8,
    localparam int NW = $clog2(W)
) (
    input  logic [W-1:0]  x,
    input  logic [NW-1:0] amt,
    input  logic          dir,
    output logic [W-1:0]  y,
    output logic          ovf
);
    always_comb begin
        ovf = 1'b0;
        if (dir == lane_shift_pkg::DIR_LEFT) begin
            y = x << amt;
            // Any set bit among the top n bits is lost
            for (int j = 1; j < W; j++) begin
                if (j <= int'(amt) && x[W-j]) ovf = 1'b1;
            end
        end else begin
            y = x >> amt;
        end
    end
endmodule

// File: rtl/ls_signed_lane.sv
module ls_signed_lane #(
    parameter int W  = 16,
    localparam int NW = $clog2(W)
) (
    input  logic [W-1:0]  x,
    input  logic [NW-1:0] amt,
    input  logic          dir,
    input  logic          sat,
    input  logic          rnd,
    output logic [W-1:0]  y,
    output logic          ovf
);
    logic [W-1:0] shl;
    logic [W-1:0] sra;
    logic         lost;
    logic         rbit;
    logic [W-1:0] clamp;

    always_comb begin
        shl  = x << amt;
        sra  = W'($signed(x) >>> amt);
        lost = 1'b0;
        // Bits that pass the sign must all equal the sign
        for (int j = 1; j < W; j++) begin
            if (j <= int'(amt) && (x[W-1-j] != x[W-1])) lost = 1'b1;
        end
        rbit = 1'b0;
        if (amt != '0) rbit = x[amt - 1'b1];
        clamp = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        if (dir == lane_shift_pkg::DIR_LEFT) begin
            ovf = lost;
            y   = (sat && lost) ? clamp : shl;
        end else begin
            ovf = 1'b0;
            y   = sra + {{(W-1){1'b0}}, rnd & rbit};
        end
    end
endmodule

// File: rtl/ls_flag_reg.sv
module ls_flag_reg #(
    parameter int FLAG_W = 8,
    parameter int IDX    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              set,
    output logic [FLAG_W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (clear) flags <= '0;
            if (set)   flags[IDX] <= 1'b1;
        end
    end
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit #(
    parameter int DATA_W  = lane_shift_pkg::WORD_W,
    parameter int FLAG_W  = lane_shift_pkg::FLAGS_W,
    parameter int OVF_IDX = lane_shift_pkg::OVF_BIT,
    localparam int AMT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] op_data,
    input  logic [AMT_W-1:0]  op_amount,
    input  logic              op_dir,
    input  logic [1:0]        op_mode,
    input  logic              op_satrnd,
    input  logic              flag_clear,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic [FLAG_W-1:0] status_flags
);
    import lane_shift_pkg::*;

    localparam int BYTE_W  = DATA_W / 4;
    localparam int HALF_W  = DATA_W / 2;
    localparam int NBYTE   = DATA_W / BYTE_W;
    localparam int NHALF   = DATA_W / HALF_W;
    localparam int BAMT_W  = $clog2(BYTE_W);
    localparam int HAMT_W  = $clog2(HALF_W);

    logic [DATA_W-1:0] byte_y, half_y, word_y;
    logic [NBYTE-1:0]  byte_ovf;
    logic [NHALF-1:0]  half_ovf;
    logic              word_ovf;
    shift_out_t        sel;
    lane_mode_e        mode;

    assign mode = lane_mode_e'(op_mode);

    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        ls_byte_lane #(.W(BYTE_W)) u_lane (
            .x   (op_data[k*BYTE_W +: BYTE_W]),
            .amt (op_amount[BAMT_W-1:0]),
            .dir (op_dir),
            .y   (byte_y[k*BYTE_W +: BYTE_W]),
            .ovf (byte_ovf[k])
        );
    end

    for (genvar k = 0; k < NHALF; k++) begin : g_half
        ls_signed_lane #(.W(HALF_W)) u_lane (
            .x   (op_data[k*HALF_W +: HALF_W]),
            .amt (op_amount[HAMT_W-1:0]),
            .dir (op_dir),
            .sat (op_satrnd),
            .rnd (op_satrnd),
            .y   (half_y[k*HALF_W +: HALF_W]),
            .ovf (half_ovf[k])
        );
    end

    // Word lane always saturates and always rounds
    ls_signed_lane #(.W(DATA_W)) u_word (
        .x   (op_data),
        .amt (op_amount),
        .dir (op_dir),
        .sat (1'b1),
        .rnd (1'b1),
        .y   (word_y),
        .ovf (word_ovf)
    );

    always_comb begin
        sel = '0;
        case (mode)
            LM_BYTE: begin
                sel.data = byte_y;
                sel.ovf  = |byte_ovf;
            end
            LM_HALF: begin
                sel.data = half_y;
                sel.ovf  = |half_ovf;
            end
            default: begin
                sel.data = word_y;
                sel.ovf  = word_ovf;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) res_data <= sel.data;
        end
    end

    ls_flag_reg #(.FLAG_W(FLAG_W), .IDX(OVF_IDX)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .clear (flag_clear),
        .set   (op_valid & sel.ovf),
        .flags (status_flags)
    );
endmodule

module lane_shift_checker #(
    parameter int DATA_W  = 32,
    parameter int FLAG_W  = 8,
    parameter int OVF_IDX = 6,
    localparam int AMT_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [DATA_W-1:0] op_data,
    input logic [AMT_W-1:0]  op_amount,
    input logic              flag_clear,
    input logic [DATA_W-1:0] res_data,
    input logic              res_valid,
    input logic [FLAG_W-1:0] status_flags
);
    localparam logic [FLAG_W-1:0] OTHER_MASK = ~(FLAG_W'(1) << OVF_IDX);

    AST_OTHER_FLAGS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_flags & OTHER_MASK) == '0); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(status_flags[OVF_IDX]) && !$past(flag_clear)) |-> status_flags[OVF_IDX]); // R10

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(op_valid))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(op_valid)) |-> $stable(res_data)); // R11

    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(op_valid) && !$past(status_flags[OVF_IDX])) |-> !status_flags[OVF_IDX]); // R11

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid) && $past(op_amount) == '0) |-> (res_data == $past(op_data))); // R9
endmodule

bind lane_shift_unit lane_shift_checker #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .OVF_IDX(OVF_IDX)
) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_data(op_data),
    .op_amount(op_amount), .flag_clear(flag_clear), .res_data(res_data),
    .res_valid(res_valid), .status_flags(status_flags)
);

// File: tb/lane_shift_unit_test.sv
module lane_shift_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [31:0] op_data = '0;
    logic [4:0]  op_amount = '0;
    logic        op_dir = 1'b0;
    logic [1:0]  op_mode = '0;
    logic        op_satrnd = 1'b0;
    logic        flag_clear = 1'b0;
    logic [31:0] res_data;
    logic        res_valid;
    logic [7:0]  status_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_data  = '0;
    logic        exp_valid = 1'b0;
    logic [7:0]  exp_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_shift_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_data(op_data),
        .op_amount(op_amount), .op_dir(op_dir), .op_mode(op_mode),
        .op_satrnd(op_satrnd), .flag_clear(flag_clear), .res_data(res_data),
        .res_valid(res_valid), .status_flags(status_flags)
    );

    // Integer reference model
    function automatic void model(input logic [31:0] d, input int a, input bit dir,
                                  input int mode, input bit sr,
                                  output logic [31:0] r, output bit ovf);
        ovf = 1'b0;
        r   = '0;
        if (mode == 0) begin
            int n = a % 8;
            for (int k = 0; k < 4; k++) begin
                int b = int'(d[8*k +: 8]);
                int v = dir ? (b >> n) : (b << n);
                if (!dir && v > 255) ovf = 1'b1;
                r[8*k +: 8] = 8'(v & 255);
            end
        end else if (mode == 1) begin
            int n = a % 16;
            for (int k = 0; k < 2; k++) begin
                longint s = longint'($signed(d[16*k +: 16]));
                longint v;
                if (!dir) begin
                    v = s * (64'sd1 << n);
                    if (v > 32767 || v < -32768) begin
                        ovf = 1'b1;
                        if (sr) v = (s >= 0) ? 32767 : -32768;
                    end
                end else begin
                    v = s >>> n;
                    if (sr && n != 0) v = v + ((s >>> (n - 1)) & 1);
                end
                r[16*k +: 16] = 16'(v & 64'hFFFF);
            end
        end else begin
            int n = a % 32;
            longint s = longint'($signed(d));
            longint v;
            if (!dir) begin
                v = s * (64'sd1 << n);
                if (v > 64'sd2147483647 || v < -64'sd2147483648) begin
                    ovf = 1'b1;
                    v = (s >= 0) ? 64'sd2147483647 : -64'sd2147483648;
                end
            end else begin
                v = s >>> n;
                if (n != 0) v = v + ((s >>> (n - 1)) & 1);
            end
            r = 32'(v & 64'hFFFFFFFF);
        end
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "res_data", res_data, exp_data);
        check(tag, "res_valid", 32'(res_valid), 32'(exp_valid));
        check(tag, "status_flags", 32'(status_flags), 32'(exp_flags));
    endtask

    // Called at a falling edge: drive, advance the model, compare at the next falling edge
    task automatic cyc(input string tag, input bit v, input logic [31:0] d, input int a,
                       input bit dir, input int mode, input bit sr, input bit clr);
        logic [31:0] r;
        bit ovf;
        op_valid = v; op_data = d; op_amount = 5'(a); op_dir = dir;
        op_mode = 2'(mode); op_satrnd = sr; flag_clear = clr;
        model(d, a, dir, mode, sr, r, ovf);
        exp_valid = v;
        if (v) exp_data = r;
        if (clr) exp_flags = '0;
        if (v && ovf) exp_flags[6] = 1'b1;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic op(input string tag, input logic [31:0] d, input int a,
                      input bit dir, input int mode, input bit sr);
        cyc(tag, 1'b1, d, a, dir, mode, sr, 1'b0);
    endtask

    task automatic clr();
        cyc("R10", 1'b0, '0, 0, 1'b0, 0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst = 1'b0;

        // R3 byte left
        op("R3", 32'h41803F01, 2, 0, 0, 1);
        clr();
        op("R3", 32'h01020304, 3, 0, 0, 0);
        op("R3", 32'h1F1F1F1F, 3, 0, 0, 1);
        clr();
        // R4 byte right
        op("R4", 32'hFF80017F, 7, 1, 0, 1);
        op("R4", 32'hA5C30F81, 3, 1, 0, 0);
        // R5 halfword left
        op("R5", 32'h4000C000, 1, 0, 1, 1);
        clr();
        op("R5", 32'h4000C000, 1, 0, 1, 0);
        clr();
        op("R5", 32'hBFFF3FFF, 2, 0, 1, 1);
        clr();
        op("R5", 32'h00010000, 15, 0, 1, 1);
        op("R5", 32'h0000FFFF, 15, 0, 1, 1);
        clr();
        // R6 halfword right
        op("R6", 32'h7FFF8001, 1, 1, 1, 1);
        op("R6", 32'h7FFF8001, 1, 1, 1, 0);
        op("R6", 32'hFFFF0003, 15, 1, 1, 1);
        // R7 word left
        op("R7", 32'h40000000, 1, 0, 2, 0);
        clr();
        op("R7", 32'hBFFFFFFF, 1, 0, 3, 0);
        clr();
        op("R7", 32'hFFFFFFFF, 31, 0, 2, 0);
        op("R7", 32'h00000001, 31, 0, 2, 1);
        clr();
        // R8 word right
        op("R8", 32'h80000001, 31, 1, 2, 0);
        op("R8", 32'h00000003, 1, 1, 3, 0);
        op("R8", 32'hFFFFFFFD, 1, 1, 2, 0);
        // R9 zero shift
        op("R9", 32'hDEADBEEF, 0, 0, 0, 1);
        op("R9", 32'h80007FFF, 0, 0, 1, 1);
        op("R9", 32'h80000000, 0, 0, 2, 1);
        op("R9", 32'h12345678, 8, 0, 0, 1);
        // R10 sticky flag, clear with overflow in the same cycle
        op("R10", 32'h80000000, 4, 0, 0, 0);
        cyc("R10", 1'b0, '0, 0, 0, 0, 0, 0);
        cyc("R10", 1'b1, 32'h40000000, 1, 0, 2, 0, 1);
        clr();
        // R11 idle cycles with overflow-producing inputs
        cyc("R11", 1'b0, 32'h40000000, 5, 0, 2, 1, 0);
        cyc("R11", 1'b0, 32'hFFFFFFFF, 3, 0, 0, 0, 0);
        // R2 back-to-back and random traffic
        for (int i = 0; i < 3000; i++) begin
            cyc("R2", 1'($urandom_range(0, 3) != 0), $urandom, int'($urandom_range(0, 31)),
                1'($urandom), int'($urandom_range(0, 3)), 1'($urandom),
                1'($urandom_range(0, 15) == 0));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule